// File: doc/BRIEF.md
# Mixed-Width Byte-Lane RAM Port

This block is a single-clock RAM port whose write word and read word have different widths. Each width is a multiple of 8 bits, and the wider width is 1, 2 or 4 times the narrower one. Software-visible data can be written as narrow words and read back as wide words, or written wide and read narrow. One address bus serves both directions. Each write carries one enable bit per byte lane, so single bytes of a wide word can be updated.

The storage is organised as byte lanes, as many as the wider side has bytes. A narrow access uses a window of those lanes, chosen by the low address bits. A wide access uses every lane of one row. Every cycle with the port enabled is a read. When byte enables are also set, the cycle is a read and a write of the same location. The write mode input then decides what the read output shows: the contents before the write, a per-byte merge of new and stored data, or no change at all.

Top module: `mixed_width_ram`

## Requirements
- R1: `addr` is a word index at the narrower of the two widths. The wider side ignores the low log2(ratio) bits of `addr`. Narrow word i of a wide word occupies its bytes i*N to i*N+N-1, where N is the narrow width in bytes (little-endian packing).
- R2: `wr_be` bit k governs `wr_data[8k+7:8k]`. Bytes whose enable is clear keep their stored contents.
- R3: A read has a latency of one clock. On the rising edge where `en` is high, `rd_data` takes the addressed read word.
- R4: While `en` is low, nothing is written, whatever `wr_be` holds, and `rd_data` keeps its value.
- R5: `wmode` = 2'b00 (read-before-write). On a write cycle, `rd_data` shows the contents of the read word from before the write.
- R6: `wmode` = 2'b01 (write-through). On a write cycle, each read byte that an enabled write byte covers shows the new data. Every other read byte shows its stored contents.
- R7: `wmode` = 2'b10 or 2'b11 (hold). On a write cycle, `rd_data` keeps its value, and the write still takes effect.
- R8: An enabled cycle with `wr_be` all zero is a plain read in every mode. It changes no storage and updates `rd_data`.
- R9: An active-low `rst_n` clears `rd_data` to zero. Memory contents are not reset.
- R10: The same rules hold when the write width is wider than the read width, for example a 32-bit write with a 16-bit read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read register |
| en | input | 1 | Port enable; a read every enabled cycle |
| addr | input | log2(DEPTH_BYTES / narrow bytes) | Word index at the narrower width |
| wr_be | input | WR_W/8 | Byte-lane write enables |
| wr_data | input | WR_W | Write data |
| wmode | input | 2 | Write mode: 00 read-before-write, 01 write-through, 1x hold |
| rd_data | output | RD_W | Registered read data |

## Verification
Every result of this block appears one rising edge after the cycle that asks for it. A read or write presented before edge n shows in `rd_data` just after edge n, and a write becomes visible to a read issued in the following cycle. The bench drives each operation at the falling edge and samples `rd_data` one nanosecond after the next rising edge. It computes the expected word from a byte-granular model, taken before the model applies that cycle's write. For idle and hold cycles, the bench carries forward the previously expected word, and a later plain read at the same location confirms whether the write landed.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [1:0] {
    WM_READ_FIRST = 2'd0,
    WM_WRITE_THRU = 2'd1,
    WM_HOLD       = 2'd2,
    WM_HOLD_ALT   = 2'd3
  } wmode_e;

  function automatic int narrow_bytes(input int wr_w, input int rd_w);
    return ((wr_w < rd_w) ? wr_w : rd_w) / 8;
  endfunction

  function automatic int lane_count(input int wr_w, input int rd_w);
    return ((wr_w > rd_w) ? wr_w : rd_w) / 8;
  endfunction

  // Width of the address bus: a word index at the narrower width (R1)
  function automatic int addr_bits(input int depth_bytes, input int wr_w, input int rd_w);
    return $clog2(depth_bytes / narrow_bytes(wr_w, rd_w));
  endfunction

  function automatic logic is_hold(input wmode_e m);
    return (m == WM_HOLD) || (m == WM_HOLD_ALT);
  endfunction

endpackage

// File: rtl/mwr_lane.sv
// One byte lane of storage: one byte per row, written synchronously,
// read combinationally so the top can merge before its output register.
module mwr_lane #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] row,
  input  logic [7:0]       wr_byte,
  output logic [7:0]       rd_byte
);

  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[row] <= wr_byte;
    end
  end

  assign rd_byte = mem[row];

endmodule

// File: rtl/mwr_addr_split.sv
// Splits the narrow-granular address into a lane row and a sub-word
// index that picks the narrow window inside the row (R1).
module mwr_addr_split #(
  parameter int ADDR_W   = 6,
  parameter int RATIO    = 4,
  parameter int RATIO_LG = 2,
  parameter int ROW_W    = 4,
  parameter int SUB_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [SUB_W-1:0]  sub
);

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return ROW_W'(a >> RATIO_LG);
  endfunction

  function automatic logic [SUB_W-1:0] sub_of(input logic [ADDR_W-1:0] a);
    return SUB_W'(a & ADDR_W'(RATIO - 1));
  endfunction

  assign row = row_of(addr);
  assign sub = sub_of(addr);

endmodule

// File: rtl/mwr_write_route.sv
// Steers write bytes and byte enables onto the storage lanes (R1, R2).
module mwr_write_route #(
  parameter int WR_B  = 1,
  parameter int LANES = 4,
  parameter int SUB_W = 2
) (
  input  logic                  en,
  input  logic [SUB_W-1:0]      sub,
  input  logic [WR_B-1:0]       wr_be,
  input  logic [WR_B*8-1:0]     wr_data,
  output logic [LANES-1:0]      lane_wr_en,
  output logic [LANES-1:0][7:0] lane_wr_byte
);

  generate
    if (WR_B == LANES) begin : g_wide_write
      // The write spans a whole row, so the sub index plays no part here.
      logic unused_sub;
      assign unused_sub = ^sub;
      for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_wr_en[j]   = en & wr_be[j];
        assign lane_wr_byte[j] = wr_data[8*j +: 8];
      end
    end else begin : g_narrow_write
      for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int WINDOW = j / WR_B;
        localparam int SLOT   = j % WR_B;
        assign lane_wr_en[j]   = en && (sub == SUB_W'(WINDOW)) && wr_be[SLOT];
        assign lane_wr_byte[j] = wr_data[8*SLOT +: 8];
      end
    end
  endgenerate

endmodule

// File: rtl/mwr_read_select.sv
// Forms the next read word: a per-lane merge for write-through (R6),
// then the narrow window or the whole row (R1).
module mwr_read_select #(
  parameter int RD_B  = 4,
  parameter int LANES = 4,
  parameter int SUB_W = 2
) (
  input  logic                  thru,
  input  logic [SUB_W-1:0]      sub,
  input  logic [LANES-1:0][7:0] lane_old,
  input  logic [LANES-1:0]      lane_wr_en,
  input  logic [LANES-1:0][7:0] lane_wr_byte,
  output logic [RD_B*8-1:0]     next_rd
);

  logic [LANES-1:0][7:0] merged;

  function automatic logic [7:0] merge_byte(input logic t, input logic hit,
                                            input logic [7:0] fresh,
                                            input logic [7:0] stored);
    return (t && hit) ? fresh : stored;
  endfunction

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      merged[j] = merge_byte(thru, lane_wr_en[j], lane_wr_byte[j], lane_old[j]);
    end
  end

  generate
    if (RD_B == LANES) begin : g_wide_read
      logic unused_sub;
      assign unused_sub = ^sub;
      assign next_rd = merged;
    end else begin : g_narrow_read
      localparam int LANE_W = $clog2(LANES);
      for (genvar k = 0; k < RD_B; k++) begin : g_byte
        logic [LANE_W-1:0] pick;
        assign pick = LANE_W'(int'(sub) * RD_B + k);
        assign next_rd[8*k +: 8] = merged[pick];
      end
    end
  endgenerate

endmodule

// File: rtl/mixed_width_ram.sv
// Single-port RAM with separately sized write and read words.
module mixed_width_ram #(
  parameter int WR_W        = 8,
  parameter int RD_W        = 32,
  parameter int DEPTH_BYTES = 64
) (
  input  logic                                                    clk,
  input  logic                                                    rst_n,
  input  logic                                                    en,
  input  logic [mwr_pkg::addr_bits(DEPTH_BYTES, WR_W, RD_W)-1:0] addr,
  input  logic [WR_W/8-1:0]                                       wr_be,
  input  logic [WR_W-1:0]                                         wr_data,
  input  logic [1:0]                                              wmode,
  output logic [RD_W-1:0]                                         rd_data
);

  import mwr_pkg::*;

  localparam int WR_B     = WR_W / 8;
  localparam int RD_B     = RD_W / 8;
  localparam int LANES    = lane_count(WR_W, RD_W);
  localparam int NARROW_B = narrow_bytes(WR_W, RD_W);
  localparam int RATIO    = LANES / NARROW_B;
  localparam int RATIO_LG = $clog2(RATIO);
  localparam int ADDR_W   = addr_bits(DEPTH_BYTES, WR_W, RD_W);
  localparam int ROWS     = DEPTH_BYTES / LANES;
  localparam int ROW_W    = ADDR_W - RATIO_LG;
  localparam int SUB_W    = (RATIO_LG == 0) ? 1 : RATIO_LG;

  wmode_e                mode;
  logic [ROW_W-1:0]      row;
  logic [SUB_W-1:0]      sub;
  logic [LANES-1:0]      lane_wr_en;
  logic [LANES-1:0][7:0] lane_wr_byte;
  logic [LANES-1:0][7:0] lane_old;
  logic [RD_W-1:0]       next_rd;

  // Named events, also observed by the bound checker
  logic wr_fire;     // an enabled cycle with at least one byte enable
  logic hold_write;  // a write in hold mode: output must not move (R7)
  logic rd_update;   // the output register loads this cycle (R3)
  logic thru;        // write-through merge selected (R6)

  assign mode       = wmode_e'(wmode);
  assign wr_fire    = en & (|wr_be);
  assign hold_write = wr_fire & is_hold(mode);
  assign rd_update  = en & ~hold_write;
  assign thru       = (mode == WM_WRITE_THRU);

  mwr_addr_split #(
    .ADDR_W  (ADDR_W),
    .RATIO   (RATIO),
    .RATIO_LG(RATIO_LG),
    .ROW_W   (ROW_W),
    .SUB_W   (SUB_W)
  ) u_addr_split (
    .addr(addr),
    .row (row),
    .sub (sub)
  );

  mwr_write_route #(
    .WR_B (WR_B),
    .LANES(LANES),
    .SUB_W(SUB_W)
  ) u_write_route (
    .en          (en),
    .sub         (sub),
    .wr_be       (wr_be),
    .wr_data     (wr_data),
    .lane_wr_en  (lane_wr_en),
    .lane_wr_byte(lane_wr_byte)
  );

  generate
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      mwr_lane #(
        .ROWS (ROWS),
        .ROW_W(ROW_W)
      ) u_lane (
        .clk    (clk),
        .wr_en  (lane_wr_en[j]),
        .row    (row),
        .wr_byte(lane_wr_byte[j]),
        .rd_byte(lane_old[j])
      );
    end
  endgenerate

  mwr_read_select #(
    .RD_B (RD_B),
    .LANES(LANES),
    .SUB_W(SUB_W)
  ) u_read_select (
    .thru        (thru),
    .sub         (sub),
    .lane_old    (lane_old),
    .lane_wr_en  (lane_wr_en),
    .lane_wr_byte(lane_wr_byte),
    .next_rd     (next_rd)
  );

  // Output register: one-clock read latency (R3), reset to zero (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_update) begin
      rd_data <= next_rd;
    end
  end

endmodule

// File: rtl/mixed_width_ram_chk.sv
module mixed_width_ram_chk #(
  parameter int WR_W  = 8,
  parameter int RD_W  = 32,
  parameter int LANES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [WR_W/8-1:0] wr_be,
  input logic [1:0]        wmode,
  input logic [RD_W-1:0]   rd_data,
  input logic [LANES-1:0]  lane_wr_en,
  input logic              wr_fire
);

  AST_IDLE_OUTPUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(rd_data)); // R4

  AST_IDLE_NO_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (lane_wr_en == '0)); // R4

  AST_HOLD_OUTPUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wmode[1]) |=> $stable(rd_data)); // R7

  AST_ONE_LANE_PER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(lane_wr_en) == $countones(wr_be))); // R2

  AST_EMPTY_ENABLES_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_be == '0) |-> (lane_wr_en == '0)); // R8

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEARS_OUTPUT: assert (rd_data == '0); // R9
    end
  end

endmodule

bind mixed_width_ram mixed_width_ram_chk #(
  .WR_W (WR_W),
  .RD_W (RD_W),
  .LANES(LANES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .wr_be     (wr_be),
  .wmode     (wmode),
  .rd_data   (rd_data),
  .lane_wr_en(lane_wr_en),
  .wr_fire   (wr_fire)
);

// File: tb/mixed_width_ram_bench.sv
`timescale 1ns/1ps
module mixed_width_ram_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // Instance A: 8-bit write, 32-bit read, 64 bytes
  logic        a_en = 1'b0;
  logic [5:0]  a_addr = '0;
  logic [0:0]  a_be = '0;
  logic [7:0]  a_din = '0;
  logic [1:0]  a_mode = '0;
  logic [31:0] a_rd;

  // Instance B: 32-bit write, 16-bit read, 64 bytes
  logic        b_en = 1'b0;
  logic [4:0]  b_addr = '0;
  logic [3:0]  b_be = '0;
  logic [31:0] b_din = '0;
  logic [1:0]  b_mode = '0;
  logic [15:0] b_rd;

  mixed_width_ram #(.WR_W(8), .RD_W(32), .DEPTH_BYTES(64)) u_mixed_width_ram (
    .clk(clk), .rst_n(rst_n), .en(a_en), .addr(a_addr), .wr_be(a_be),
    .wr_data(a_din), .wmode(a_mode), .rd_data(a_rd));

  mixed_width_ram #(.WR_W(32), .RD_W(16), .DEPTH_BYTES(64)) u_mixed_width_ram_wide (
    .clk(clk), .rst_n(rst_n), .en(b_en), .addr(b_addr), .wr_be(b_be),
    .wr_data(b_din), .wmode(b_mode), .rd_data(b_rd));

  logic [7:0]  mem_a [64];
  logic [7:0]  mem_b [64];
  logic [31:0] a_exp = '0;
  logic [15:0] b_exp = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string rq);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // One cycle on instance A, checked one edge later
  task automatic step_a(input logic e, input int ad, input logic be,
                        input logic [7:0] d, input logic [1:0] m, input string rq);
    logic [31:0] exp;
    int base;
    @(negedge clk);
    a_en = e; a_addr = 6'(ad); a_be = be; a_din = d; a_mode = m;
    exp = a_exp;
    if (e) begin
      if (!(be && m[1])) begin
        base = (ad / 4) * 4;
        for (int k = 0; k < 4; k++) begin
          exp[8*k +: 8] = (m == 2'b01 && be && (base + k) == ad) ? d : mem_a[base + k];
        end
      end
      if (be) mem_a[ad] = d;
    end
    a_exp = exp;
    @(posedge clk); #1;
    compare(a_rd, exp, rq);
    a_en = 1'b0; a_be = '0;
  endtask

  // One cycle on instance B, checked one edge later
  task automatic step_b(input logic e, input int ad, input logic [3:0] be,
                        input logic [31:0] d, input logic [1:0] m, input string rq);
    logic [15:0] exp;
    int wbase;
    int idx;
    @(negedge clk);
    b_en = e; b_addr = 5'(ad); b_be = be; b_din = d; b_mode = m;
    exp = b_exp;
    wbase = (ad / 2) * 4;
    if (e) begin
      if (!((be != 4'b0) && m[1])) begin
        for (int k = 0; k < 2; k++) begin
          idx = ad * 2 + k;
          if (m == 2'b01 && idx >= wbase && idx < wbase + 4 && be[idx - wbase])
            exp[8*k +: 8] = d[8*(idx - wbase) +: 8];
          else
            exp[8*k +: 8] = mem_b[idx];
        end
      end
      for (int k = 0; k < 4; k++) begin
        if (be[k]) mem_b[wbase + k] = d[8*k +: 8];
      end
    end
    b_exp = exp;
    @(posedge clk); #1;
    compare(32'(b_rd), 32'(exp), rq);
    b_en = 1'b0; b_be = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    compare(a_rd, 32'h0, "R9");
    compare(32'(b_rd), 32'h0, "R9");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Fill both memories in hold mode; the outputs must stay at zero
  task automatic t_fill_hold();
    for (int i = 0; i < 64; i++) step_a(1'b1, i, 1'b1, 8'(i * 37 + 5), 2'b10, "R7");
    for (int r = 0; r < 16; r++)
      step_b(1'b1, r * 2, 4'hF, (32'(r) * 32'h01010101) ^ 32'hA55A3CC3, 2'b11, "R7");
  endtask

  task automatic t_narrow_write_wide_read();
    step_a(1'b1, 0, 1'b0, 8'h00, 2'b00, "R3");
    step_a(1'b1, 7, 1'b0, 8'h00, 2'b00, "R1");  // low bits ignored: row 1
    step_a(1'b1, 63, 1'b0, 8'h00, 2'b01, "R1");
  endtask

  task automatic t_read_first();
    step_a(1'b1, 10, 1'b1, 8'hC3, 2'b00, "R5");
    step_a(1'b1, 8, 1'b0, 8'h00, 2'b00, "R2");  // lane 2 holds new byte
    step_b(1'b1, 9, 4'hF, 32'h0BADF00D, 2'b00, "R5");
    step_b(1'b1, 8, 4'h0, 32'h0, 2'b00, "R1");
  endtask

  task automatic t_write_through();
    step_a(1'b1, 21, 1'b1, 8'h5A, 2'b01, "R6");
    step_a(1'b1, 20, 1'b0, 8'h00, 2'b01, "R6");
    step_b(1'b1, 6, 4'b0110, 32'h11223344, 2'b01, "R6");
    step_b(1'b1, 7, 4'b0000, 32'h0, 2'b01, "R6");
    step_b(1'b1, 7, 4'b1000, 32'hAB000000, 2'b01, "R6");
  endtask

  task automatic t_hold_then_read();
    step_a(1'b1, 33, 1'b1, 8'h77, 2'b10, "R7");
    step_a(1'b1, 34, 1'b1, 8'h88, 2'b11, "R7");
    step_a(1'b1, 32, 1'b0, 8'h00, 2'b10, "R8");  // plain read in hold mode
    step_a(1'b1, 33, 1'b0, 8'h00, 2'b11, "R8");
  endtask

  task automatic t_idle();
    step_a(1'b0, 40, 1'b1, 8'hEE, 2'b01, "R4");
    step_a(1'b1, 40, 1'b0, 8'h00, 2'b00, "R4");
    step_b(1'b0, 2, 4'hF, 32'hFFFFFFFF, 2'b00, "R4");
    step_b(1'b1, 2, 4'h0, 32'h0, 2'b00, "R4");
  endtask

  task automatic t_wide_write_narrow_read();
    step_b(1'b1, 4, 4'b0101, 32'hDEADBEEF, 2'b00, "R10");
    step_b(1'b1, 4, 4'b0000, 32'h0, 2'b00, "R2");
    step_b(1'b1, 5, 4'b0000, 32'h0, 2'b00, "R2");
    step_b(1'b1, 31, 4'b0000, 32'h0, 2'b00, "R10");
  endtask

  initial begin
    t_reset();
    t_fill_hold();
    t_narrow_write_wide_read();
    t_read_first();
    t_write_through();
    t_hold_then_read();
    t_idle();
    t_wide_write_narrow_read();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule